// File: doc/BRIEF.md
# Horizontal Slot Timing Generator

This block derives the horizontal timing of one scanline for a tile-based video processor. A free-running divider turns the system clock into access-slot strobes, and an 8-bit slot counter advances on each strobe. The counter does not count linearly. Each mode has its own range of values that the counter skips. A narrow line therefore holds 171 slots and a wide line holds 210.

The interrupt, blanking and sync markers are placed on this skipped sequence. Each one is a registered flag that changes only when the counter moves. In wide mode the slot period stretches for the slots around sync, so that sync lasts about as long in absolute time as it does in narrow mode.

The mode input is latched only when the counter wraps to slot 0x00. A request made part way through a line therefore applies from the next line on. An enable input freezes the whole generator while it is low.

Top module: `hslot_timing_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the outputs after that edge are: `slot_cnt` = 0x00, `wide_mode` = 0 (narrow), and `slot_stb`, `line_start`, `hint_pulse`, `hblank` and `hsync` all 0. After reset the three flags stay low until the counter first enters their start slot.
- R2: In narrow mode (`wide_mode` = 0) every slot lasts 20 enabled clocks, so a full line is 3420 clocks.
- R3: In wide mode (`wide_mode` = 1) a slot lasts 16 enabled clocks. The exceptions are slots 0xE6 through 0xF6, which last 20 clocks each, so a full line is 3428 clocks.
- R4: In narrow mode the counter steps from 0x93 straight to 0xE9 and counts by one everywhere else, giving 171 slots per line.
- R5: In wide mode the counter steps from 0xB6 straight to 0xE5 and counts by one everywhere else, giving 210 slots per line.
- R6: The counter wraps from 0xFF to 0x00. `line_start` is high for exactly the first clock of slot 0x00.
- R7: `hint_pulse` is high for the whole of slot 0x85 in narrow mode and for the whole of slot 0xA5 in wide mode, and low otherwise.
- R8: `hblank` is high from the first clock of slot 0x93 through the last clock of slot 0x05 in narrow mode (30 slots). In wide mode it is high from slot 0xB4 through slot 0x06 (37 slots). The mode of the slot being entered selects the limits.
- R9: `hsync` is high from slot 0xEC through slot 0xF8 in narrow mode (13 slots) and from slot 0xE7 through slot 0xF6 in wide mode (16 slots). It is only ever high while `hblank` is high.
- R10: `wide_req` is sampled only on the strobe that wraps the counter to 0x00. `wide_mode` shows the mode in effect and changes only in the first clock of a line.
- R11: While `run_en` is low, no strobe is issued and `slot_cnt`, the divider phase and all flags hold their values.
- R12: `slot_stb` is a single-clock pulse in the first clock of every new slot, and `slot_cnt` changes only in those clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wide_req | input | 1 | Requested mode: 0 narrow, 1 wide; applied at the next line start |
| run_en | input | 1 | Advance enable; low freezes the generator |
| slot_stb | output | 1 | High in the first clock of each slot |
| slot_cnt | output | 8 | Current slot number on the skipped sequence |
| line_start | output | 1 | High in the first clock of slot 0x00 |
| hint_pulse | output | 1 | High for the whole of the interrupt slot |
| hblank | output | 1 | Horizontal blanking flag |
| hsync | output | 1 | Horizontal sync flag |
| wide_mode | output | 1 | Mode in effect for the current line |

## Verification
A wrong divider phase or period shows on `slot_stb` within one slot, which is 16 to 20 clocks, and it pushes every later counter step out of line. A wrong gap entry or a wrong mode latch shows on `slot_cnt` at the first strobe after the bad state. The flag outputs then diverge within the same slot. A flag register that sets or clears on the wrong slot only shows when the counter passes that slot. The worst case is one full line, about 3428 clocks. For that reason the comparison runs on every clock over several lines in both modes, across a mid-line mode request, a pause and a mid-line reset.

// File: rtl/hslot_pkg.sv
// Package: shared types for the horizontal slot timing generator.
// Assumes: exactly two horizontal modes. The enum value doubles as the index
//          into the per-mode tables.
package hslot_pkg;

    typedef enum logic {
        MODE_NARROW = 1'b0,
        MODE_WIDE   = 1'b1
    } hmode_e;

    localparam int NUM_MODES = 2;

endpackage

// File: rtl/hslot_divider.sv
// Module: hslot_divider
// Counts enabled clocks. Raises tick in the last clock of each slot period.
// Assumes: period is at least 2, and it changes only in the clock that
//          follows a tick, because it is derived from the slot that has
//          just been entered.
module hslot_divider #(
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] period,
    output logic             tick
);

    logic [DIV_W-1:0] phase;

    // Tick when the phase reaches the last clock of the period.
    always_comb begin
        tick = en && (phase == (period - DIV_W'(1)));
    end

    // Advance the phase while enabled and restart it after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (en) begin
            if (tick) phase <= '0;
            else      phase <= phase + DIV_W'(1);
        end
    end

    // R2 R3
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase < period);

    // R11
    phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(en) && $past(rst_n)) |-> (phase == $past(phase)));

endmodule

// File: rtl/hslot_sequencer.sv
// Module: hslot_sequencer
// Holds the slot counter and the mode in effect. Steps the counter on each
// divider tick, jumps over the gap of the active mode and latches the
// requested mode at the wrap to zero. Picks the slot period for the divider.
// Assumes: gap_lo < gap_hi in each mode, and the stretched range lies
//          outside the wide-mode gap.
module hslot_sequencer
    import hslot_pkg::*;
#(
    parameter int          SLOT_W       = 8,
    parameter int          DIV_W        = 5,
    parameter int          NARROW_DIV   = 20,
    parameter int          WIDE_DIV     = 16,
    parameter logic [7:0]  N_GAP_LO     = 8'h93,
    parameter logic [7:0]  N_GAP_HI     = 8'hE9,
    parameter logic [7:0]  W_GAP_LO     = 8'hB6,
    parameter logic [7:0]  W_GAP_HI     = 8'hE5,
    parameter logic [7:0]  W_STRETCH_LO = 8'hE6,
    parameter logic [7:0]  W_STRETCH_HI = 8'hF6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wide_req,
    output logic [SLOT_W-1:0] cnt,
    output logic [SLOT_W-1:0] cnt_nxt,
    output hmode_e            mode_act,
    output hmode_e            mode_nxt,
    output logic [DIV_W-1:0]  period,
    output logic              stb_q,
    output logic              ls_q
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

    logic [SLOT_W-1:0] gap_lo [NUM_MODES];
    logic [SLOT_W-1:0] gap_hi [NUM_MODES];
    logic              wrap;
    logic              in_stretch;

    // Per-mode gap tables, one entry per mode.
    for (genvar m = 0; m < NUM_MODES; m++) begin : g_gap
        if (m == int'(MODE_WIDE)) begin : g_wide
            assign gap_lo[m] = SLOT_W'(W_GAP_LO);
            assign gap_hi[m] = SLOT_W'(W_GAP_HI);
        end else begin : g_narrow
            assign gap_lo[m] = SLOT_W'(N_GAP_LO);
            assign gap_hi[m] = SLOT_W'(N_GAP_HI);
        end
    end

    // Next slot value, the wrap condition and the mode of the next slot.
    always_comb begin
        wrap = (cnt == LAST_SLOT);
        if (cnt == gap_lo[mode_act]) cnt_nxt = gap_hi[mode_act];
        else                         cnt_nxt = cnt + SLOT_W'(1);
        mode_nxt = wrap ? hmode_e'(wide_req) : mode_act;
    end

    // Slot period: wide slots stretch to the narrow length around sync.
    always_comb begin
        in_stretch = (cnt >= SLOT_W'(W_STRETCH_LO)) && (cnt <= SLOT_W'(W_STRETCH_HI));
        if (mode_act == MODE_WIDE && !in_stretch) period = DIV_W'(WIDE_DIV);
        else                                      period = DIV_W'(NARROW_DIV);
    end

    // Counter, mode latch, strobe and line-start registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            mode_act <= MODE_NARROW;
            stb_q    <= 1'b0;
            ls_q     <= 1'b0;
        end else begin
            stb_q <= tick;
            ls_q  <= tick && wrap;
            if (tick) begin
                cnt      <= cnt_nxt;
                mode_act <= mode_nxt;
            end
        end
    end

    // R4 R5
    no_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((cnt > gap_lo[mode_act]) && (cnt < gap_hi[mode_act])));

    // R12
    cnt_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != $past(cnt)) |-> stb_q);

    // R12
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |=> !stb_q);

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act != $past(mode_act)) |-> ls_q);

    // R6
    ls_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ls_q |-> (cnt == '0 && stb_q));

endmodule

// File: rtl/hslot_window.sv
// Module: hslot_window
// One timing flag. It sets when the counter enters the start slot of the
// active mode and clears when it enters the slot after the end slot.
// Assumes: the start and stop values of each mode are reachable values of
//          the skipped sequence and differ from each other.
module hslot_window
    import hslot_pkg::*;
#(
    parameter int         SLOT_W = 8,
    parameter logic [7:0] N_ON   = 8'h00,
    parameter logic [7:0] N_OFF  = 8'h01,
    parameter logic [7:0] W_ON   = 8'h00,
    parameter logic [7:0] W_OFF  = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic [SLOT_W-1:0] nxt,
    input  hmode_e            nxt_mode,
    input  logic [SLOT_W-1:0] cur,
    input  hmode_e            cur_mode,
    output logic              flag
);

    logic [SLOT_W-1:0] on_v;
    logic [SLOT_W-1:0] off_v;

    // Start and stop values for the mode of the slot being entered.
    always_comb begin
        on_v  = (nxt_mode == MODE_WIDE) ? SLOT_W'(W_ON)  : SLOT_W'(N_ON);
        off_v = (nxt_mode == MODE_WIDE) ? SLOT_W'(W_OFF) : SLOT_W'(N_OFF);
    end

    // Set on entry to the start slot and clear on entry to the stop slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (adv) begin
            if (nxt == on_v)       flag <= 1'b1;
            else if (nxt == off_v) flag <= 1'b0;
        end
    end

    // R7 R8 R9
    window_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cur == ((cur_mode == MODE_WIDE) ? SLOT_W'(W_ON) : SLOT_W'(N_ON))));

    // R7 R8 R9
    window_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> (cur == ((cur_mode == MODE_WIDE) ? SLOT_W'(W_OFF) : SLOT_W'(N_OFF))));

endmodule

// File: rtl/hslot_timing_gen.sv
// Module: hslot_timing_gen (top)
// Horizontal slot timing. A clock divider drives a skipped-sequence slot
// counter, and three window flags decode interrupt, blanking and sync from
// that counter.
// Assumes: rst_n is synchronous and active low. wide_req may change at any
//          time but only takes effect at the next line start.
module hslot_timing_gen
    import hslot_pkg::*;
#(
    parameter int         SLOT_W       = 8,
    parameter int         NARROW_DIV   = 20,
    parameter int         WIDE_DIV     = 16,
    parameter logic [7:0] N_GAP_LO     = 8'h93,
    parameter logic [7:0] N_GAP_HI     = 8'hE9,
    parameter logic [7:0] W_GAP_LO     = 8'hB6,
    parameter logic [7:0] W_GAP_HI     = 8'hE5,
    parameter logic [7:0] W_STRETCH_LO = 8'hE6,
    parameter logic [7:0] W_STRETCH_HI = 8'hF6,
    parameter logic [7:0] N_HINT       = 8'h85,
    parameter logic [7:0] W_HINT       = 8'hA5,
    parameter logic [7:0] N_BLANK_ON   = 8'h93,
    parameter logic [7:0] N_BLANK_OFF  = 8'h06,
    parameter logic [7:0] W_BLANK_ON   = 8'hB4,
    parameter logic [7:0] W_BLANK_OFF  = 8'h07,
    parameter logic [7:0] N_SYNC_ON    = 8'hEC,
    parameter logic [7:0] N_SYNC_OFF   = 8'hF9,
    parameter logic [7:0] W_SYNC_ON    = 8'hE7,
    parameter logic [7:0] W_SYNC_OFF   = 8'hF7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wide_req,
    input  logic              run_en,
    output logic              slot_stb,
    output logic [SLOT_W-1:0] slot_cnt,
    output logic              line_start,
    output logic              hint_pulse,
    output logic              hblank,
    output logic              hsync,
    output logic              wide_mode
);

    localparam int         MAX_DIV  = (NARROW_DIV > WIDE_DIV) ? NARROW_DIV : WIDE_DIV;
    localparam int         DIV_W    = $clog2(MAX_DIV + 1);
    localparam logic [7:0] N_HINT_X = N_HINT + 8'd1;
    localparam logic [7:0] W_HINT_X = W_HINT + 8'd1;

    logic              tick;
    logic [DIV_W-1:0]  period;
    logic [SLOT_W-1:0] cnt;
    logic [SLOT_W-1:0] cnt_nxt;
    hmode_e            mode_act;
    hmode_e            mode_nxt;
    logic              stb_q;
    logic              ls_q;

    hslot_divider #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (run_en),
        .period (period),
        .tick   (tick)
    );

    hslot_sequencer #(
        .SLOT_W       (SLOT_W),
        .DIV_W        (DIV_W),
        .NARROW_DIV   (NARROW_DIV),
        .WIDE_DIV     (WIDE_DIV),
        .N_GAP_LO     (N_GAP_LO),
        .N_GAP_HI     (N_GAP_HI),
        .W_GAP_LO     (W_GAP_LO),
        .W_GAP_HI     (W_GAP_HI),
        .W_STRETCH_LO (W_STRETCH_LO),
        .W_STRETCH_HI (W_STRETCH_HI)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wide_req (wide_req),
        .cnt      (cnt),
        .cnt_nxt  (cnt_nxt),
        .mode_act (mode_act),
        .mode_nxt (mode_nxt),
        .period   (period),
        .stb_q    (stb_q),
        .ls_q     (ls_q)
    );

    hslot_window #(
        .SLOT_W (SLOT_W), .N_ON (N_HINT), .N_OFF (N_HINT_X),
        .W_ON (W_HINT), .W_OFF (W_HINT_X)
    ) u_hint (
        .clk (clk), .rst_n (rst_n), .adv (tick), .nxt (cnt_nxt),
        .nxt_mode (mode_nxt), .cur (cnt), .cur_mode (mode_act), .flag (hint_pulse)
    );

    hslot_window #(
        .SLOT_W (SLOT_W), .N_ON (N_BLANK_ON), .N_OFF (N_BLANK_OFF),
        .W_ON (W_BLANK_ON), .W_OFF (W_BLANK_OFF)
    ) u_blank (
        .clk (clk), .rst_n (rst_n), .adv (tick), .nxt (cnt_nxt),
        .nxt_mode (mode_nxt), .cur (cnt), .cur_mode (mode_act), .flag (hblank)
    );

    hslot_window #(
        .SLOT_W (SLOT_W), .N_ON (N_SYNC_ON), .N_OFF (N_SYNC_OFF),
        .W_ON (W_SYNC_ON), .W_OFF (W_SYNC_OFF)
    ) u_sync (
        .clk (clk), .rst_n (rst_n), .adv (tick), .nxt (cnt_nxt),
        .nxt_mode (mode_nxt), .cur (cnt), .cur_mode (mode_act), .flag (hsync)
    );

    // Drive the remaining outputs from the sequencer registers.
    always_comb begin
        slot_stb   = stb_q;
        slot_cnt   = cnt;
        line_start = ls_q;
        wide_mode  = (mode_act == MODE_WIDE);
    end

    // R9
    sync_in_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> hblank);

    // R11
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(run_en) && $past(rst_n)) |-> (!slot_stb && $stable(slot_cnt)));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !$past(rst_n) |-> (slot_cnt == '0 && !slot_stb && !hblank && !hsync && !hint_pulse));

endmodule

// File: tb/hslot_timing_gen_tb.sv
`timescale 1ns/1ps
module hslot_timing_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wide_req = 1'b0;
    logic       run_en = 1'b1;
    logic       slot_stb, line_start, hint_pulse, hblank, hsync, wide_mode;
    logic [7:0] slot_cnt;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    hslot_timing_gen u_dut (
        .clk (clk), .rst_n (rst_n), .wide_req (wide_req), .run_en (run_en),
        .slot_stb (slot_stb), .slot_cnt (slot_cnt), .line_start (line_start),
        .hint_pulse (hint_pulse), .hblank (hblank), .hsync (hsync),
        .wide_mode (wide_mode)
    );

    // Behavioural reference model
    int m_div = 0, m_cnt = 0, m_wide = 0;
    int m_stb = 0, m_ls = 0, m_hint = 0, m_hb = 0, m_hs = 0;

    function automatic int slot_len(int c, int w);
        if (w != 0 && c >= 'hE6 && c <= 'hF6) return 20;
        return (w != 0) ? 16 : 20;
    endfunction

    function automatic int following(int c, int w);
        if (w == 0 && c == 'h93) return 'hE9;
        if (w != 0 && c == 'hB6) return 'hE5;
        return (c + 1) % 256;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_div = 0; m_cnt = 0; m_wide = 0;
            m_stb = 0; m_ls = 0; m_hint = 0; m_hb = 0; m_hs = 0;
        end else if (run_en) begin
            if (m_div == slot_len(m_cnt, m_wide) - 1) begin
                int n;
                n = following(m_cnt, m_wide);
                m_div = 0; m_stb = 1; m_ls = (n == 0);
                if (n == 0) m_wide = wide_req;
                m_cnt = n;
                if (n == (m_wide ? 'hA5 : 'h85)) m_hint = 1;
                else if (n == (m_wide ? 'hA6 : 'h86)) m_hint = 0;
                if (n == (m_wide ? 'hB4 : 'h93)) m_hb = 1;
                else if (n == (m_wide ? 'h07 : 'h06)) m_hb = 0;
                if (n == (m_wide ? 'hE7 : 'hEC)) m_hs = 1;
                else if (n == (m_wide ? 'hF7 : 'hF9)) m_hs = 0;
            end else begin
                m_div++; m_stb = 0; m_ls = 0;
            end
        end else begin
            m_stb = 0; m_ls = 0;
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("R12", "slot_stb",   slot_stb,   m_stb);
            chk("R4/R5", "slot_cnt", slot_cnt,   m_cnt);
            chk("R6",  "line_start", line_start, m_ls);
            chk("R7",  "hint_pulse", hint_pulse, m_hint);
            chk("R8",  "hblank",     hblank,     m_hb);
            chk("R9",  "hsync",      hsync,      m_hs);
            chk("R10", "wide_mode",  wide_mode,  m_wide);
        end
    end

    // Port monitor: line length in slots and clocks, gap transitions
    int slot_ct = 0, clk_ct = 0, last_slots = 0, last_clks = 0;
    int prev_cnt = 0, after_93 = -1, after_b6 = -1, stb_total = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            slot_ct = 0; clk_ct = 0; last_slots = 0; last_clks = 0;
        end else begin
            if (slot_stb) begin
                stb_total++;
                if (prev_cnt == 'h93 && !wide_mode) after_93 = slot_cnt;
                if (prev_cnt == 'hB6 && wide_mode)  after_b6 = slot_cnt;
            end
            if (line_start) begin
                last_slots = slot_ct; last_clks = clk_ct;
                slot_ct = 1; clk_ct = 1;
            end else begin
                if (slot_stb) slot_ct++;
                clk_ct++;
            end
        end
        prev_cnt = slot_cnt;
    end

    task automatic wait_clks(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic wait_ls();
        do begin @(posedge clk); #1; end while (!line_start);
    endtask

    task automatic check_reset_state(input string tag);
        chk("R1", {tag, " slot_cnt"}, slot_cnt, 0);
        chk("R1", {tag, " flags"}, {slot_stb, line_start, hint_pulse, hblank, hsync}, 0);
        chk("R1", {tag, " wide_mode"}, wide_mode, 0);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            finish_run();
        end
    end

    initial begin
        wait_clks(5);
        check_reset_state("R1 initial");
        rst_n = 1'b1;

        // Narrow lines: 171 slots, 3420 clocks, gap 0x93 -> 0xE9 (R2, R4)
        wait_ls(); wait_ls(); #3;
        chk("R4", "narrow slots/line", last_slots, 171);
        chk("R2", "narrow clocks/line", last_clks, 3420);
        chk("R4", "slot after 0x93", after_93, 'hE9);

        // Mid-line mode request must wait for the wrap (R10)
        wait_clks(500);
        wide_req = 1'b1;
        wait_clks(200);
        chk("R10", "mode held mid-line", wide_mode, 0);
        wait_ls();
        chk("R10", "mode at line start", wide_mode, 1);
        chk("R6", "slot at line start", slot_cnt, 0);

        // Wide line: 210 slots, 3428 clocks, gap 0xB6 -> 0xE5 (R3, R5)
        wait_ls(); #3;
        chk("R5", "wide slots/line", last_slots, 210);
        chk("R3", "wide clocks/line", last_clks, 3428);
        chk("R5", "slot after 0xB6", after_b6, 'hE5);

        // Pause: nothing moves while run_en is low (R11)
        wait_clks(300);
        run_en = 1'b0;
        begin
            int c0, s0, hb0;
            wait_clks(1);
            c0 = slot_cnt; s0 = stb_total; hb0 = hblank;
            wait_clks(60);
            chk("R11", "slot_cnt frozen", slot_cnt, c0);
            chk("R11", "no strobes", stb_total, s0);
            chk("R11", "hblank frozen", hblank, hb0);
        end
        run_en = 1'b1;

        // Back to narrow; measure a clean line (R4, R2)
        wide_req = 1'b0;
        wait_ls(); wait_ls(); wait_ls(); #3;
        chk("R4", "narrow slots again", last_slots, 171);
        chk("R2", "narrow clocks again", last_clks, 3420);

        // Wide again, then reset in the middle of a line (R1)
        wide_req = 1'b1;
        wait_ls();
        wait_clks(1900);
        rst_n = 1'b0;
        wait_clks(3);
        check_reset_state("R1 mid-line");
        rst_n = 1'b1;
        wait_ls(); wait_ls(); #3;
        chk("R5", "wide after reset", last_slots, 210);

        finish_run();
    end

endmodule